// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block controls a parameterised number of general-purpose pins, up to 31, from a plain 32-bit register bus. Software sets each pin's direction and drives output levels. Two write-only strobe registers do the driving: one raises the pins whose bits are written as 1, and the other lowers them. Every pin input passes through a two-flop synchroniser before it can be read back or used for interrupt detection.

Each pin has its own interrupt configuration. Separate registers hold the trigger kind (level or edge) and the active sense (high/rising or low/falling). An enable bit decides whether a pin records events at all. A mask bit decides whether a recorded event reaches the single combined interrupt line. Edge events latch until software reads the pending register. Level events follow the pin for as long as the pin stays at its active level.

A build parameter flips the meaning of the direction register. This lets one design serve sites whose output-enable sense is inverted.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: An asserted reset clears every register. While reset is held and after it is released, pin_out is 0, irq is 0, and every readable register reads 0. In the normal variant pin_oe is 0 (all pins inputs); in the inverted variant pin_oe is all ones.
- R2: The direction register is at byte offset 0x00 and reads back what was written. With OE_INVERT=0, pin_oe bit i equals direction bit i. With OE_INVERT=1, pin_oe bit i equals the inverse of direction bit i.
- R3: Writing offset 0x0C sets to 1 every pin_out bit whose write-data bit is 1. Writing offset 0x10 clears to 0 every pin_out bit whose write-data bit is 1. Bits written as 0 leave pin_out unchanged. Both offsets read back as 0.
- R4: Offset 0x04 reads the synchronised pin levels, which are valid three cycles after a pin changes. Writes to this offset have no effect.
- R5: Offset 0x18 holds the trigger kind, where 0 means edge and 1 means level. Offset 0x1C holds the sense. For an edge pin, sense 1 latches a pending bit on a rising edge and sense 0 latches it on a falling edge. An edge in the other direction records nothing.
- R6: For a level pin, the pending bit at offset 0x20 is 1 exactly while the synchronised pin level equals its sense bit.
- R7: A read of offset 0x20 returns the pending bits and clears the latched edge bits in the same cycle. Level pending bits are not cleared by the read.
- R8: Offset 0x14 holds the per-pin enable. A pin whose enable bit is 0 records no pending bit, and enabling it later does not recover past events.
- R9: Offset 0x24 holds the per-pin mask. irq is 1 exactly when some pin has its pending, enable and mask bits all at 1. A masked pin's event stays pending, and it raises irq once its mask bit is set.
- R10: Register bits at and above PIN_COUNT are dropped on write and read as 0.
- R11: bus_rdata carries the data of a read in the cycle after bus_rd. It is 0 in any cycle that follows no read. Unmapped offsets read 0, and writes to offsets 0x04 and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output drive levels |
| pin_oe | output | PIN_COUNT | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two copies that share one bus. The main copy has 8 pins and normal direction sense. Its narrow width lets write data carry bits above the pin count, so the dropped-bit rule can be checked on every configuration register. It is also where each interrupt mode, the clear-on-read behaviour and the enable-versus-mask split are exercised. The second copy has the maximum 31 pins and the inverted direction sense. It shows that a reset leaves its outputs all enabled, and that bit 31 still reads 0 at full width.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word indices (byte offset / 4); software decodes these
  localparam int unsigned WIDX_DIR   = 0;
  localparam int unsigned WIDX_IN    = 1;
  localparam int unsigned WIDX_SET   = 3;
  localparam int unsigned WIDX_CLR   = 4;
  localparam int unsigned WIDX_IEN   = 5;
  localparam int unsigned WIDX_ITYPE = 6;
  localparam int unsigned WIDX_IPOL  = 7;
  localparam int unsigned WIDX_IPEND = 8;
  localparam int unsigned WIDX_IMASK = 9;
  localparam int unsigned BUS_W      = 32;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl      = lvl_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic         clr,
  output logic [W-1:0] edge_lat,
  output logic [W-1:0] pend
);
  logic [W-1:0] ev, edge_q, edge_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    assign hit   = pol[i] ? (lvl[i] & ~lvl_prev[i]) : (~lvl[i] & lvl_prev[i]);
    assign ev[i] = en[i] & ~typ[i] & hit;
    assign pend[i] = typ[i] ? (en[i] & (lvl[i] == pol[i])) : edge_q[i];
  end

  always_comb begin
    edge_d = edge_q;
    if (clr) edge_d = '0;
    edge_d = edge_d | ev;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) edge_q <= '0;
    else         edge_q <= edge_d;
  end

  assign edge_lat = edge_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rd,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      pend,
  output logic [BUS_W-1:0]  rdata,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      en,
  output logic [W-1:0]      typ,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      msk,
  output logic              pend_clr
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [W-1:0] wv;
  logic [W-1:0] dir_q, dir_d, out_q, out_d, en_q, en_d;
  logic [W-1:0] typ_q, typ_d, pol_q, pol_d, msk_q, msk_d;
  logic [W-1:0] rsel;
  logic [BUS_W-1:0] rdata_q, rdata_d;

  assign word = addr[ADDR_W-1:2];
  assign wv   = wdata[W-1:0];

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    en_d  = en_q;
    typ_d = typ_q;
    pol_d = pol_q;
    msk_d = msk_q;
    if (wr) begin
      case (word)
        WORD_W'(WIDX_DIR):   dir_d = wv;
        WORD_W'(WIDX_SET):   out_d = out_q | wv;
        WORD_W'(WIDX_CLR):   out_d = out_q & ~wv;
        WORD_W'(WIDX_IEN):   en_d  = wv;
        WORD_W'(WIDX_ITYPE): typ_d = wv;
        WORD_W'(WIDX_IPOL):  pol_d = wv;
        WORD_W'(WIDX_IMASK): msk_d = wv;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (word)
      WORD_W'(WIDX_DIR):   rsel = dir_q;
      WORD_W'(WIDX_IN):    rsel = lvl;
      WORD_W'(WIDX_IEN):   rsel = en_q;
      WORD_W'(WIDX_ITYPE): rsel = typ_q;
      WORD_W'(WIDX_IPOL):  rsel = pol_q;
      WORD_W'(WIDX_IPEND): rsel = pend;
      WORD_W'(WIDX_IMASK): rsel = msk_q;
      default:             rsel = '0;
    endcase
    rdata_d = rd ? BUS_W'(rsel) : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      en_q    <= '0;
      typ_q   <= '0;
      pol_q   <= '0;
      msk_q   <= '0;
      rdata_q <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      en_q    <= en_d;
      typ_q   <= typ_d;
      pol_q   <= pol_d;
      msk_q   <= msk_d;
      rdata_q <= rdata_d;
    end
  end

  assign pend_clr = rd && (word == WORD_W'(WIDX_IPEND));
  assign rdata    = rdata_q;
  assign dir      = dir_q;
  assign dout     = out_q;
  assign en       = en_q;
  assign typ      = typ_q;
  assign pol      = pol_q;
  assign msk      = msk_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16,
  parameter bit          OE_INVERT = 1'b0,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_rd,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic                 irq
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic [PIN_COUNT-1:0] lvl, lvl_prev, dir_q, out_q, en_q, typ_q, pol_q, msk_q;
  logic [PIN_COUNT-1:0] edge_lat, pend;
  logic pend_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  gpio_in_sync #(.W(PIN_COUNT)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .raw(pin_in), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  gpio_regs #(.W(PIN_COUNT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .lvl(lvl), .pend(pend), .rdata(bus_rdata), .dir(dir_q),
    .dout(out_q), .en(en_q), .typ(typ_q), .pol(pol_q), .msk(msk_q),
    .pend_clr(pend_clr)
  );

  gpio_irq_detect #(.W(PIN_COUNT)) u_detect (
    .clk(clk), .rst_ni(rst_ni), .lvl(lvl), .lvl_prev(lvl_prev), .en(en_q),
    .typ(typ_q), .pol(pol_q), .clr(pend_clr), .edge_lat(edge_lat), .pend(pend)
  );

  if (OE_INVERT) begin : g_oe_inv
    assign pin_oe = ~dir_q;
  end else begin : g_oe_norm
    assign pin_oe = dir_q;
  end

  assign pin_out = out_q;
  assign irq     = |(pend & en_q & msk_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic                 bus_rd,
  input logic [BUS_W-1:0]     bus_rdata,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic                 irq,
  input logic [PIN_COUNT-1:0] en_q,
  input logic [PIN_COUNT-1:0] msk_q,
  input logic [PIN_COUNT-1:0] edge_lat
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  logic is_set, is_clr;
  logic [PIN_COUNT-1:0] wv;
  assign is_set = bus_wr && (bus_addr[ADDR_W-1:2] == WORD_W'(WIDX_SET));
  assign is_clr = bus_wr && (bus_addr[ADDR_W-1:2] == WORD_W'(WIDX_CLR));
  assign wv     = bus_wdata[PIN_COUNT-1:0];

  assert_set_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_set) |-> ((pin_out & $past(wv)) == $past(wv)));

  assert_clr_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_clr) |-> ((pin_out & $past(wv)) == '0));

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == '0));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:PIN_COUNT] == '0);

  assert_edge_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_lat & ~$past(edge_lat) & ~$past(en_q)) == '0));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en_q & msk_q) != '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .irq(irq), .en_q(en_q), .msk_q(msk_q), .edge_lat(edge_lat)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  localparam int unsigned NP = 8;
  localparam int unsigned NI = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_i;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NI-1:0] pin_in_i = '0, pin_out_i, pin_oe_i;
  logic irq, irq_i;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.PIN_COUNT(NP), .OE_INVERT(1'b0), .ADDR_W(8)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  gpio_irq_ctrl #(.PIN_COUNT(NI), .OE_INVERT(1'b1), .ADDR_W(8)) u_gpio_irq_ctrl_inv (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_i),
    .pin_in(pin_in_i), .pin_out(pin_out_i), .pin_oe(pin_oe_i), .irq(irq_i)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // op: 0 write, 1 read and compare, 2 compare pin_out, 3 compare pin_oe
  localparam int NV = 23;
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 4'd2,  8'h00, 32'h0000FF0F},
    {2'd1, 4'd2,  8'h00, 32'h0000000F},  // R2
    {2'd3, 4'd2,  8'h00, 32'h0000000F},  // R2
    {2'd0, 4'd3,  8'h0C, 32'h0000003C},
    {2'd2, 4'd3,  8'h00, 32'h0000003C},  // R3
    {2'd0, 4'd3,  8'h10, 32'h00000014},
    {2'd2, 4'd3,  8'h00, 32'h00000028},  // R3
    {2'd1, 4'd3,  8'h0C, 32'h00000000},  // R3
    {2'd1, 4'd3,  8'h10, 32'h00000000},  // R3
    {2'd0, 4'd3,  8'h0C, 32'h00000000},
    {2'd0, 4'd3,  8'h10, 32'h00000000},
    {2'd2, 4'd3,  8'h00, 32'h00000028},  // R3
    {2'd0, 4'd10, 8'h18, 32'h000001F0},
    {2'd1, 4'd10, 8'h18, 32'h000000F0},  // R10
    {2'd0, 4'd5,  8'h1C, 32'h000000AA},
    {2'd1, 4'd5,  8'h1C, 32'h000000AA},  // R5
    {2'd0, 4'd8,  8'h14, 32'h0000003C},
    {2'd1, 4'd8,  8'h14, 32'h0000003C},  // R8
    {2'd0, 4'd9,  8'h24, 32'h0000010F},
    {2'd1, 4'd9,  8'h24, 32'h0000000F},  // R9 R10
    {2'd0, 4'd4,  8'h04, 32'h000000FF},
    {2'd1, 4'd4,  8'h04, 32'h00000000},  // R4
    {2'd1, 4'd11, 8'h28, 32'h00000000}   // R11
  };

  initial begin : watchdog
    wait_cyc(100000);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    wait_cyc(3);
    // R1: outputs during reset
    check("R1", 32'(pin_out), 32'h0);
    check("R1", 32'(pin_oe), 32'h0);
    check("R1", 32'(pin_oe_i), 32'h7FFFFFFF);
    check("R1", 32'(irq), 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic [3:0] rq;
      logic [7:0] ad;
      logic [31:0] dv;
      {op, rq, ad, dv} = VEC[v];
      case (op)
        2'd0: bus_write(ad, dv);
        2'd1: begin bus_read(ad, rv); check($sformatf("R%0d", rq), rv, dv); end
        2'd2: check($sformatf("R%0d", rq), 32'(pin_out), dv);
        default: check($sformatf("R%0d", rq), 32'(pin_oe), dv);
      endcase
    end

    // R2 inverted variant: direction 0xFF0F kept at 31 bits
    check("R2", 32'(pin_oe_i), 32'h7FFF00F0);
    // R10 at both widths
    bus_write(8'h24, 32'hFFFFFFFF);
    bus_read(8'h24, rv);
    check("R10", rv, 32'h000000FF);
    check("R10", rdata_i, 32'h7FFFFFFF);
    // R11 pending offset ignores writes (nothing enabled as edge; level bit4 low active)
    bus_write(8'h14, 32'h0);
    bus_write(8'h20, 32'hFF);
    bus_read(8'h20, rv);
    check("R11", rv, 32'h0);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(2);
    check("R1", 32'(pin_out), 32'h0);
    check("R1", 32'(pin_oe), 32'h0);
    check("R1", 32'(irq), 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);
    bus_read(8'h00, rv); check("R1", rv, 32'h0);
    bus_read(8'h24, rv); check("R1", rv, 32'h0);
    bus_read(8'h1C, rv); check("R1", rv, 32'h0);

    // R4 input sampling
    pin_in = 8'h5A;
    wait_cyc(4);
    bus_read(8'h04, rv); check("R4", rv, 32'h5A);
    pin_in = 8'h00;
    wait_cyc(4);

    // interrupt config: bit0 rise, bit1 fall, bit2 level high, bit3 level low,
    // bit4 disabled, bit5 rise enabled but masked
    bus_write(8'h18, 32'h0C);
    bus_write(8'h1C, 32'h35);
    bus_write(8'h24, 32'h0F);
    bus_write(8'h14, 32'h2F);
    wait_cyc(4);
    bus_read(8'h20, rv); check("R6", rv, 32'h08);
    check("R9", 32'(irq), 32'h1);
    pin_in[3] = 1'b1; wait_cyc(4);
    bus_read(8'h20, rv); check("R6", rv, 32'h00);
    check("R9", 32'(irq), 32'h0);

    pin_in[0] = 1'b1; wait_cyc(4);
    check("R9", 32'(irq), 32'h1);
    bus_read(8'h20, rv); check("R5", rv, 32'h01);
    check("R7", 32'(irq), 32'h0);
    bus_read(8'h20, rv); check("R7", rv, 32'h00);

    pin_in[1] = 1'b1; wait_cyc(4);
    bus_read(8'h20, rv); check("R5", rv, 32'h00);
    pin_in[1] = 1'b0; wait_cyc(4);
    bus_read(8'h20, rv); check("R5", rv, 32'h02);

    pin_in[2] = 1'b1; wait_cyc(4);
    bus_read(8'h20, rv); check("R6", rv, 32'h04);
    bus_read(8'h20, rv); check("R7", rv, 32'h04);
    check("R9", 32'(irq), 32'h1);
    pin_in[2] = 1'b0; wait_cyc(4);
    bus_read(8'h20, rv); check("R6", rv, 32'h00);
    check("R6", 32'(irq), 32'h0);

    pin_in[4] = 1'b1; wait_cyc(4);
    check("R8", 32'(irq), 32'h0);
    bus_write(8'h14, 32'h3F);
    wait_cyc(2);
    bus_read(8'h20, rv); check("R8", rv, 32'h00);

    pin_in[5] = 1'b1; wait_cyc(4);
    check("R9", 32'(irq), 32'h0);
    bus_write(8'h24, 32'h2F);
    wait_cyc(1);
    check("R9", 32'(irq), 32'h1);
    bus_read(8'h20, rv); check("R9", rv, 32'h20);
    check("R7", 32'(irq), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule